// File: doc/BRIEF.md
# SD Command Line Controller

This block drives the command line of an SD/MMC host. A single write of a command control word, with its enable bit set, loads a 48-bit command frame and shifts it out one bit per clock, most significant bit first. The frame holds a start bit, a host-direction bit, the 6-bit index, the 32-bit argument, a CRC7 and an end bit. Each clock cycle is one card clock. After the end bit the block either finishes or releases the line and listens for a reply. The reply is a short 48-bit frame or a long 136-bit frame, chosen by a 2-bit code in the control word. The block checks the reply's CRC7 where the code asks for it and stores the reply in four 32-bit words.

Sticky flags report completion, CRC failure, reply timeout, end of busy and busy timeout. Software clears them by writing ones. A live busy bit and a live active bit sit in the same status word. If D0 is low on the last reply bit, the block waits for the card to release D0. A loadable down-counter bounds that wait. The data-transfer and stop bits of the control word only appear on two outputs while a command is in flight; a neighbouring data path can use them.

States: IDLE, SEND, WAIT (listening for a start bit), RECV (shifting the reply in) and BUSY (D0 held low). Transitions:
- IDLE→SEND on an enable write.
- SEND→IDLE after the end bit when no reply is expected.
- SEND→WAIT after the end bit when a reply is expected.
- WAIT→RECV on a low command line.
- WAIT→IDLE on timeout.
- RECV→BUSY on the last reply bit with D0 low and no CRC error.
- RECV→IDLE on the last reply bit otherwise.
- BUSY→IDLE on D0 release or on counter expiry.
- Any state→IDLE on a write with the enable bit clear.

Top module: `sdcmd_path`

## Requirements
- R1: Starting in the cycle after an enable write in IDLE, `cmd_oe` is high for 48 cycles. During those cycles `cmd_out` carries 0, 1, index[5:0], argument[31:0], CRC7 and 1, MSB first. The CRC7 uses polynomial x^7+x^3+1 with a zero start value, computed over the first 40 bits (an all-zero index and argument give a final byte of 0x95).
- R2: With reply code 00 the block sets status bit 7 after the end bit and returns to IDLE without listening.
- R3: With code 01 or 10 the block receives a 48-bit reply, stores reply bits 39:8 in `resp0_o`, and sets status bit 6. Code 10 never checks the CRC.
- R4: With code 01 or 11, a reply whose CRC7 does not match sets status bit 0 instead of bit 6.
- R5: With code 11 the block receives a 136-bit reply and stores its last 128 bits in `resp0_o` (most significant) through `resp3_o`. The CRC is checked over reply bits 127:1.
- R6: If the command line stays high for 64 cycles after the end bit, status bit 2 is set and the block returns to IDLE. A start bit seen in the 64th cycle is accepted.
- R7: If D0 is low in the last reply cycle and the CRC is good, status bit 20 is high while the block waits. Status bit 21 is set when D0 goes high.
- R8: If D0 stays low for more than `dtimer_in`+1 cycles of busy, status bit 3 is set instead of bit 21 and the block returns to IDLE.
- R9: A write on the clear port clears each flag of bits 11:0 and 28:21 whose mask bit is 1. Flags whose mask bit is 0 keep their value.
- R10: Status bit 13 is high exactly while the block is not in IDLE.
- R11: An enable-clear write aborts an active command: the next cycle is IDLE with the line released. An enable write while the block is active is ignored and does not change the frame being sent.
- R12: `xfer_data_o` and `stop_o` show the data-transfer and stop bits of the active command, and are low in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_enable | input | 1 | Enable bit of the control word |
| ctl_index | input | 6 | Command index |
| ctl_data | input | 1 | Command carries a data transfer |
| ctl_stop | input | 1 | Command is a stop command |
| ctl_wait | input | 2 | Reply code: 00 none, 01 short checked, 10 short unchecked, 11 long |
| arg_in | input | 32 | Command argument, sampled at the enable write |
| dtimer_in | input | DTIMER_W | Busy wait limit, sampled on entering BUSY |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 29 | Ones select flags to clear |
| cmd_in | input | 1 | Command line as seen from the card |
| d0_in | input | 1 | Data line 0, low while the card is busy |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| xfer_data_o | output | 1 | Active command has a data transfer |
| stop_o | output | 1 | Active command is a stop command |
| status_o | output | 32 | Sticky flags plus live bits 13 and 20 |
| resp0_o | output | 32 | Reply word 0 |
| resp1_o | output | 32 | Reply word 1 |
| resp2_o | output | 32 | Reply word 2 |
| resp3_o | output | 32 | Reply word 3 |

## Verification
If the bit counter or shift register is off by one, the frame captured at the line is shifted or too short. The bench sees that on the first command, within 48 cycles of the write. If the state register lands in the wrong state after the end bit, either bit 7 is set when a reply was expected or bit 2 is set 64 cycles later. A bad CRC accumulator enable window flips bits 6 and 0 on the first checked reply. A stuck busy path shows as bit 13 staying high until the watchdog trips.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY
    } cmd_state_e;

    localparam int FLAG_W = 29;
    localparam logic [FLAG_W-1:0] STATIC_MASK = 29'h1FE0_0FFF;

    localparam int B_CCRC = 0;
    localparam int B_CTO  = 2;
    localparam int B_DTO  = 3;
    localparam int B_REND = 6;
    localparam int B_SENT = 7;
    localparam int B_ACT  = 13;
    localparam int B_BUSY = 20;
    localparam int B_BEND = 21;

    localparam logic [1:0] RW_NONE      = 2'b00;
    localparam logic [1:0] RW_SHORT_CRC = 2'b01;
    localparam logic [1:0] RW_SHORT_RAW = 2'b10;
    localparam logic [1:0] RW_LONG      = 2'b11;

    localparam logic [6:0] CRC7_TAPS = 7'h09;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? CRC7_TAPS : 7'h00);
    endfunction

endpackage

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    localparam int BODY_W = 2 + IDX_W + ARG_W,
    localparam int FRAME_W = BODY_W + 8
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [ARG_W-1:0]   arg,
    output logic [FRAME_W-1:0] frame
);

    logic [BODY_W-1:0] body;
    logic [6:0]        crc;

    always_comb begin
        body = {1'b0, 1'b1, idx, arg};
        crc  = 7'h00;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            crc = crc7_step(crc, body[i]);
        end
        frame = {body, crc, 1'b1};
    end

endmodule

// File: rtl/sdcmd_crc7_acc.sv
module sdcmd_crc7_acc
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       bit_in,
    output logic [6:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 7'h00;
        end else if (clear) begin
            crc <= 7'h00;
        end else if (shift_en) begin
            crc <= crc7_step(crc, bit_in);
        end
    end

endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags
    import sdcmd_pkg::*;
#(
    parameter int W = FLAG_W,
    parameter logic [W-1:0] KEEP_MASK = STATIC_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags
);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? (clr_mask & KEEP_MASK) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_eff) | (set_vec & KEEP_MASK);
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(clr_mask & KEEP_MASK & ~set_vec)) == '0)); // R9

    AST_ZERO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask))); // R9

endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
    import sdcmd_pkg::*;
#(
    parameter int RSP_TIMEOUT = 64,
    parameter int DTIMER_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                ctl_enable,
    input  logic [5:0]          ctl_index,
    input  logic                ctl_data,
    input  logic                ctl_stop,
    input  logic [1:0]          ctl_wait,
    input  logic [31:0]         arg_in,
    input  logic [DTIMER_W-1:0] dtimer_in,
    input  logic                clr_we,
    input  logic [28:0]         clr_mask,
    input  logic                cmd_in,
    input  logic                d0_in,
    output logic                cmd_out,
    output logic                cmd_oe,
    output logic                xfer_data_o,
    output logic                stop_o,
    output logic [31:0]         status_o,
    output logic [31:0]         resp0_o,
    output logic [31:0]         resp1_o,
    output logic [31:0]         resp2_o,
    output logic [31:0]         resp3_o
);

    localparam int SHORT_LEN = 48;
    localparam int LONG_LEN  = 136;
    localparam int CRC_TOP   = 127;
    localparam int CNT_W     = $clog2(LONG_LEN);
    localparam int TMO_W     = $clog2(RSP_TIMEOUT + 1);
    localparam int RX_W      = 128;

    cmd_state_e state, nstate;

    logic [SHORT_LEN-1:0] frame;
    logic [SHORT_LEN-1:0] tx_sr;
    logic [CNT_W-1:0]     bit_cnt;
    logic [TMO_W-1:0]     tmr;
    logic [DTIMER_W-1:0]  dcnt;
    logic [1:0]           rsp_wait_q;
    logic                 data_q;
    logic                 stop_q;
    logic [RX_W-1:0]      rx_sr;
    logic [RX_W-1:0]      rx_next;
    logic [6:0]           rx_crc;
    logic [FLAG_W-1:0]    flags;
    logic [FLAG_W-1:0]    set_vec;

    logic start_cmd, abort_req, long_q, check_q, crc_bad, crc_en, crc_clr;
    logic ev_sent, ev_rend, ev_ccrc, ev_cto, ev_bend, ev_dto, rsp_done;

    sdcmd_frame #(.IDX_W(6), .ARG_W(32)) u_frame (
        .idx   (ctl_index),
        .arg   (arg_in),
        .frame (frame)
    );

    sdcmd_crc7_acc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clr),
        .shift_en (crc_en),
        .bit_in   (cmd_in),
        .crc      (rx_crc)
    );

    sdcmd_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    always_comb begin
        start_cmd = ctl_we && ctl_enable && (state == ST_IDLE);
        abort_req = ctl_we && !ctl_enable && (state != ST_IDLE);
        long_q    = (rsp_wait_q == RW_LONG);
        check_q   = (rsp_wait_q == RW_SHORT_CRC) || (rsp_wait_q == RW_LONG);
        crc_bad   = check_q && (rx_crc != 7'h00);
        crc_clr   = (state == ST_WAIT);
        crc_en    = (state == ST_RECV) && (bit_cnt != '0) &&
                    (!long_q || (bit_cnt <= CNT_W'(CRC_TOP)));
        rx_next   = {rx_sr[RX_W-2:0], cmd_in};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next state and completion events
    always_comb begin
        nstate   = state;
        ev_sent  = 1'b0;
        ev_rend  = 1'b0;
        ev_ccrc  = 1'b0;
        ev_cto   = 1'b0;
        ev_bend  = 1'b0;
        ev_dto   = 1'b0;
        rsp_done = 1'b0;
        if (abort_req) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_cmd) nstate = ST_SEND;
                end
                ST_SEND: begin
                    if (bit_cnt == '0) begin
                        if (rsp_wait_q == RW_NONE) begin
                            ev_sent = 1'b1;
                            nstate  = ST_IDLE;
                        end else begin
                            nstate = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!cmd_in) begin
                        nstate = ST_RECV;
                    end else if (tmr == TMO_W'(RSP_TIMEOUT - 1)) begin
                        ev_cto = 1'b1;
                        nstate = ST_IDLE;
                    end
                end
                ST_RECV: begin
                    if (bit_cnt == '0) begin
                        rsp_done = 1'b1;
                        ev_ccrc  = crc_bad;
                        ev_rend  = !crc_bad;
                        nstate   = (!crc_bad && !d0_in) ? ST_BUSY : ST_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (d0_in) begin
                        ev_bend = 1'b1;
                        nstate  = ST_IDLE;
                    end else if (dcnt == '0) begin
                        ev_dto = 1'b1;
                        nstate = ST_IDLE;
                    end
                end
                default: nstate = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr      <= '0;
            bit_cnt    <= '0;
            tmr        <= '0;
            dcnt       <= '0;
            rsp_wait_q <= RW_NONE;
            data_q     <= 1'b0;
            stop_q     <= 1'b0;
            rx_sr      <= '0;
            resp0_o    <= '0;
            resp1_o    <= '0;
            resp2_o    <= '0;
            resp3_o    <= '0;
        end else begin
            if (start_cmd) begin
                tx_sr      <= frame;
                bit_cnt    <= CNT_W'(SHORT_LEN - 1);
                rsp_wait_q <= ctl_wait;
                data_q     <= ctl_data;
                stop_q     <= ctl_stop;
            end
            case (state)
                ST_SEND: begin
                    tx_sr   <= {tx_sr[SHORT_LEN-2:0], 1'b1};
                    bit_cnt <= bit_cnt - 1'b1;
                    tmr     <= '0;
                end
                ST_WAIT: begin
                    tmr     <= tmr + 1'b1;
                    bit_cnt <= long_q ? CNT_W'(LONG_LEN - 2) : CNT_W'(SHORT_LEN - 2);
                end
                ST_RECV: begin
                    rx_sr   <= rx_next;
                    bit_cnt <= bit_cnt - 1'b1;
                    if (rsp_done && !abort_req) begin
                        dcnt <= dtimer_in;
                        if (long_q) begin
                            resp0_o <= rx_next[127:96];
                            resp1_o <= rx_next[95:64];
                            resp2_o <= rx_next[63:32];
                            resp3_o <= rx_next[31:0];
                        end else begin
                            resp0_o <= rx_next[39:8];
                        end
                    end
                end
                ST_BUSY: begin
                    dcnt <= dcnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_oe      = (state == ST_SEND);
        cmd_out     = cmd_oe ? tx_sr[SHORT_LEN-1] : 1'b1;
        xfer_data_o = (state != ST_IDLE) && data_q;
        stop_o      = (state != ST_IDLE) && stop_q;

        set_vec         = '0;
        set_vec[B_SENT] = ev_sent;
        set_vec[B_REND] = ev_rend;
        set_vec[B_CCRC] = ev_ccrc;
        set_vec[B_CTO]  = ev_cto;
        set_vec[B_BEND] = ev_bend;
        set_vec[B_DTO]  = ev_dto;

        status_o         = {3'b000, flags};
        status_o[B_ACT]  = (state != ST_IDLE);
        status_o[B_BUSY] = (state == ST_BUSY);
    end

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out); // R1

    AST_END_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && bit_cnt == '0) |-> cmd_out); // R1

    AST_NO_RSP_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && bit_cnt == '0 && rsp_wait_q == RW_NONE && !abort_req)
        |=> (status_o[B_SENT] && state == ST_IDLE)); // R2

    AST_CRC_REND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_vec[B_REND] && set_vec[B_CCRC])); // R4

    AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_CTO]) |-> ($past(state) == ST_WAIT)); // R6

    AST_BUSY_END_D0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_BEND]) |-> $past(d0_in)); // R7

    AST_DTO_D0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_DTO]) |-> !$past(d0_in)); // R8

    AST_OE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> status_o[B_ACT]); // R10

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (state == ST_IDLE && !cmd_oe)); // R11

endmodule

// File: tb/sdcmd_path_bench.sv
module sdcmd_path_bench;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  wt;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [31:0] cst;
        logic        bad;
        logic        dat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 6'd0,  32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{2'd1, 6'd17, 32'h0000_1000, 32'h0000_0900, 1'b0, 1'b1},
        '{2'd1, 6'd13, 32'h1234_5678, 32'h0000_0B00, 1'b1, 1'b0},
        '{2'd2, 6'd41, 32'h00FF_8000, 32'h80FF_8000, 1'b1, 1'b0},
        '{2'd2, 6'd55, 32'hDEAD_BEEF, 32'h0000_0120, 1'b0, 1'b1},
        '{2'd1, 6'd63, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_enable = 1'b0, ctl_data = 1'b0, ctl_stop = 1'b0;
    logic [5:0]  ctl_index = '0;
    logic [1:0]  ctl_wait = '0;
    logic [31:0] arg_in = '0;
    logic [31:0] dtimer_in = 32'd1000;
    logic        clr_we = 1'b0;
    logic [28:0] clr_mask = '0;
    logic        cmd_in = 1'b1, d0_in = 1'b1;
    logic        cmd_out, cmd_oe, xfer_data_o, stop_o;
    logic [31:0] status_o, resp0_o, resp1_o, resp2_o, resp3_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic oe_gap;

    always #(CLK_P / 2) clk = ~clk;

    sdcmd_path u_sdcmd_path (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_index(ctl_index), .ctl_data(ctl_data), .ctl_stop(ctl_stop),
        .ctl_wait(ctl_wait), .arg_in(arg_in), .dtimer_in(dtimer_in),
        .clr_we(clr_we), .clr_mask(clr_mask), .cmd_in(cmd_in), .d0_in(d0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .xfer_data_o(xfer_data_o),
        .stop_o(stop_o), .status_o(status_o), .resp0_o(resp0_o),
        .resp1_o(resp1_o), .resp2_o(resp2_o), .resp3_o(resp3_o)
    );

    function automatic logic [6:0] bcrc(input logic [127:0] m, input int n);
        logic [134:0] w;
        w = 135'(m) << 7;
        for (int i = n + 6; i >= 7; i--) begin
            if (w[i]) w[i -: 8] = w[i -: 8] ^ 8'h89;
        end
        return w[6:0];
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, bcrc(128'({2'b01, idx, arg}), 40), 1'b1};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic issue(input logic en, input logic [5:0] idx, input logic [1:0] wt,
                         input logic dat, input logic stp, input logic [31:0] arg);
        ctl_we = 1'b1; ctl_enable = en; ctl_index = idx; ctl_wait = wt;
        ctl_data = dat; ctl_stop = stp; arg_in = arg;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clear_all;
        clr_we = 1'b1; clr_mask = '1;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic grab(output logic [47:0] f, input int inj);
        f = '0;
        oe_gap = 1'b0;
        for (int i = 0; i < 48; i++) begin
            if (i == inj) begin
                ctl_we = 1'b1; ctl_enable = 1'b1; ctl_index = 6'd9; ctl_wait = 2'd0;
            end else begin
                ctl_we = 1'b0;
            end
            f = {f[46:0], cmd_out};
            if (!cmd_oe) oe_gap = 1'b1;
            @(negedge clk);
        end
        ctl_we = 1'b0;
    endtask

    task automatic reply(input logic [135:0] bits, input int len, input int dly, input logic d0_last);
        cmd_in = 1'b1;
        repeat (dly) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = bits[i];
            if (i == 0 && d0_last) d0_in = 1'b0;
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 400 && status_o[13]; i++) @(negedge clk);
    endtask

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] cst,
                                               input logic bad);
        logic [6:0] c;
        c = bcrc(128'({2'b00, idx, cst}), 40) ^ {6'b0, bad};
        return 136'({2'b00, idx, cst, c, 1'b1});
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [47:0]  f;
        logic [31:0]  exp_st;
        logic [119:0] body;
        logic [127:0] payload;
        logic [135:0] lrsp;

        repeat (3) @(negedge clk);
        check("R10 reset status", 128'(status_o), 128'(0));
        check("R1 reset oe", 128'(cmd_oe), 128'(0));
        check("R1 reset line", 128'(cmd_out), 128'(1));
        check("R5 reset resp", 128'({resp0_o, resp1_o, resp2_o, resp3_o}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // table of commands walked by one loop
        for (int v = 0; v < 6; v++) begin
            clear_all();
            issue(1'b1, VECS[v].idx, VECS[v].wt, VECS[v].dat, VECS[v].dat, VECS[v].arg);
            check("R12 data bit in flight", 128'(xfer_data_o), 128'(VECS[v].dat));
            check("R12 stop bit in flight", 128'(stop_o), 128'(VECS[v].dat));
            check("R10 active while sending", 128'(status_o[13]), 128'(1));
            grab(f, -1);
            check("R1 frame", 128'(f), 128'(exp_frame(VECS[v].idx, VECS[v].arg)));
            check("R1 oe held", 128'(oe_gap), 128'(0));
            if (v == 0) check("R1 known crc", 128'(f), 128'(48'h40_0000_0000_95));
            if (VECS[v].wt != 2'd0)
                reply(short_rsp(VECS[v].idx, VECS[v].cst, VECS[v].bad), 48, 3, 1'b0);
            wait_idle();
            exp_st = '0;
            case (VECS[v].wt)
                2'd0: exp_st[7] = 1'b1;                          // R2
                2'd1: if (VECS[v].bad) exp_st[0] = 1'b1;         // R4
                      else exp_st[6] = 1'b1;                     // R3
                default: exp_st[6] = 1'b1;                       // R3 no check
            endcase
            check("R2 R3 R4 status", 128'(status_o), 128'(exp_st));
            if (VECS[v].wt != 2'd0)
                check("R3 resp0", 128'(resp0_o), 128'(VECS[v].cst));
            check("R12 idle bits", 128'({xfer_data_o, stop_o}), 128'(0));
        end

        // R9: write-one-to-clear, zeros untouched
        issue(1'b1, 6'd2, 2'd0, 1'b0, 1'b0, 32'h0);
        grab(f, -1);
        wait_idle();
        check("R9 both flags set", 128'(status_o), 128'(32'h0000_00C0));
        clr_we = 1'b1; clr_mask = 29'h40;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
        check("R9 one flag cleared", 128'(status_o), 128'(32'h0000_0080));
        clr_we = 1'b1; clr_mask = 29'h0;
        @(negedge clk);
        clr_we = 1'b0;
        check("R9 zero mask no effect", 128'(status_o), 128'(32'h0000_0080));

        // R5: long reply good and bad CRC
        for (int b = 0; b < 2; b++) begin
            clear_all();
            body    = {32'h0123_4567, 32'h89AB_CDEF, 32'h0F1E_2D3C, 24'h4B_5A69};
            payload = {body, bcrc(128'(body), 120) ^ 7'(b), 1'b1};
            lrsp    = {2'b00, 6'b111111, payload};
            issue(1'b1, 6'd2, 2'd3, 1'b0, 1'b0, 32'h0);
            grab(f, -1);
            reply(lrsp, 136, 2, 1'b0);
            wait_idle();
            check("R5 long words", 128'({resp0_o, resp1_o, resp2_o, resp3_o}), payload);
            check("R5 R4 long status", 128'(status_o),
                  (b == 0) ? 128'(32'h40) : 128'(32'h1));
        end

        // R6: timeout after 64 idle cycles, start bit in 64th cycle accepted
        clear_all();
        issue(1'b1, 6'd8, 2'd1, 1'b0, 1'b0, 32'h1AA);
        grab(f, -1);
        repeat (64) @(negedge clk);
        check("R6 timeout", 128'(status_o), 128'(32'h4));
        clear_all();
        issue(1'b1, 6'd8, 2'd1, 1'b0, 1'b0, 32'h1AA);
        grab(f, -1);
        reply(short_rsp(6'd8, 32'h1AA, 1'b0), 48, 63, 1'b0);
        wait_idle();
        check("R6 late start accepted", 128'(status_o), 128'(32'h40));

        // R7: busy on D0 then release
        clear_all();
        dtimer_in = 32'd1000;
        issue(1'b1, 6'd12, 2'd1, 1'b0, 1'b1, 32'h0);
        grab(f, -1);
        reply(short_rsp(6'd12, 32'h0000_0B00, 1'b0), 48, 1, 1'b1);
        check("R7 busy live", 128'(status_o[20]), 128'(1));
        repeat (5) @(negedge clk);
        check("R7 busy still", 128'(status_o[20]), 128'(1));
        d0_in = 1'b1;
        @(negedge clk);
        check("R7 busy end", 128'(status_o), 128'(32'h0020_0040));

        // R8: busy outlasts data timer
        clear_all();
        dtimer_in = 32'd4;
        issue(1'b1, 6'd12, 2'd1, 1'b0, 1'b0, 32'h0);
        grab(f, -1);
        reply(short_rsp(6'd12, 32'h0000_0B00, 1'b0), 48, 1, 1'b1);
        repeat (4) @(negedge clk);
        check("R8 busy before expiry", 128'(status_o[20]), 128'(1));
        @(negedge clk);
        check("R8 data timeout", 128'(status_o), 128'(32'h48));
        d0_in = 1'b1;

        // R11: enable write while active ignored; clear write aborts
        clear_all();
        issue(1'b1, 6'd5, 2'd0, 1'b0, 1'b0, 32'hCAFE_0001);
        grab(f, 5);
        check("R11 rewrite ignored", 128'(f), 128'(exp_frame(6'd5, 32'hCAFE_0001)));
        wait_idle();
        clear_all();
        issue(1'b1, 6'd6, 2'd1, 1'b0, 1'b0, 32'h0);
        repeat (10) @(negedge clk);
        issue(1'b0, 6'd0, 2'd0, 1'b0, 1'b0, 32'h0);
        check("R11 abort idle", 128'({status_o[13], cmd_oe}), 128'(0));
        repeat (70) @(negedge clk);
        check("R11 abort no flags", 128'(status_o), 128'(0));

        summary();
        $finish;
    end

endmodule